// File: doc/BRIEF.md
# Register-Memory ALU with Status Flags

This block is the execute stage of a small 32-bit core. It handles two-operand instructions that pair a register with an r/m operand. Operand fetch and address generation happen upstream. Each cycle the core presents four inputs:

- the opcode byte,
- the 3-bit reg sub-field of the addressing byte,
- the register operand,
- the r/m operand.

One clock later the block returns the result, whether the write goes to the r/m location or to the register, a write-enable, and the sign, zero and overflow flags.

The operations are add, subtract, AND, OR, XOR, compare and NOT. For the two-operand operations, opcode bit 1 chooses the direction:

- When bit 1 is clear, the register is the source and the r/m operand is the destination.
- When bit 1 is set, the roles swap.

Compare updates only the flags. Add and subtract update both the flags and the destination. The logic operations write a result and leave the flags untouched. Any opcode the block does not recognise leaves all state alone. When the core is idle it simply presents such an opcode.

Top module: `regmem_alu`

## Requirements
- R1: While reset is asserted, and after release until a recognised opcode is presented, `result`, `wr_en`, `dest_is_rm`, `sf`, `zf` and `of` are all 0. Asserting reset clears them at once, without waiting for a clock.
- R2: Opcode bit 1 selects the direction. Opcodes 0x01, 0x29, 0x21, 0x09, 0x31 take the r/m operand as destination and drive `dest_is_rm`=1. Opcodes 0x03, 0x2B, 0x23, 0x0B, 0x33 take the register as destination and drive `dest_is_rm`=0.
- R3: Opcodes 0x01 and 0x03 write destination plus source, modulo 2^32.
- R4: Opcodes 0x29 and 0x2B write destination minus source, modulo 2^32.
- R5: Opcodes 0x21/0x23 write the bitwise AND, 0x09/0x0B the bitwise OR, and 0x31/0x33 the bitwise exclusive-or of the operands. All of them assert `wr_en` and leave `sf`, `zf` and `of` unchanged.
- R6: Opcode 0xF7 with reg field 3'b010 writes the bitwise inverse of the r/m operand, with `dest_is_rm`=1, and leaves the flags unchanged. Opcode 0xF7 with any other reg field is unrecognised.
- R7: Opcode 0x39 compares r/m minus register, and 0x3B compares register minus r/m. Both update the flags and hold `wr_en` at 0.
- R8: After add, subtract or compare, `sf` equals bit 31 of the 32-bit difference or sum, and `zf` is 1 exactly when that 32-bit value is zero.
- R9: After add, subtract or compare, `of` is 1 exactly when the 32-bit signed outcome differs from the exact signed outcome.
- R10: Any other opcode, including 0x11 and 0x19, holds `wr_en` at 0 and leaves the flags unchanged.
- R11: All outputs are registered. Values presented before a rising clock edge appear on the outputs just after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 8 | Instruction opcode byte |
| reg_fld | input | 3 | Reg sub-field of the addressing byte |
| reg_opnd | input | DATA_W (32) | Register operand |
| rm_opnd | input | DATA_W (32) | r/m operand |
| result | output | DATA_W (32) | Value to write back |
| dest_is_rm | output | 1 | 1: write goes to the r/m location, 0: to the register |
| wr_en | output | 1 | Write-back enable |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| of | output | 1 | Overflow flag |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Operand swap between paired opcodes.** A design that ignored opcode bit 1 would subtract, or compare, in the wrong order. That shows up as 9 turning into -9 and as an inverted sign flag.
- **Signed overflow in both directions.** The bench drives 0x7FFFFFFF+1, 0x80000000+0x80000000, 0x7FFFFFFF-(-1) and 0x80000000-1. An overflow test built on carry-out, or on only one operand's sign, would miss some of these.
- **Flag holding.** After a compare has left nonzero flags, the bench issues logic operations, NOT, compare-free unknown opcodes and 0xF7 with a wrong reg field. A design that updated flags there would clear them.
- **XOR against OR.** The bench checks XOR on overlapping bit patterns, where an OR would leave 0xAABBCCDD instead of 0x0A0BCCDD.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_OR,
    OP_XOR,
    OP_CMP,
    OP_NOT,
    OP_NONE
  } alu_op_e;

  typedef struct packed {
    logic sf;
    logic zf;
    logic of;
  } alu_flags_t;

  // Unary group opcode and the sub-operation selecting inversion
  localparam logic [7:0] OPC_UNARY  = 8'hF7;
  localparam logic [2:0] SUBOP_INV  = 3'd2;

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [2:0] reg_fld,
  output alu_op_e    op,
  output logic       dst_is_rm,
  output logic       wr_req,
  output logic       flg_upd
);
  // Two-operand family: bits 7:6 clear, bits 2:0 = 0x1 or 0x3,
  // bits 5:3 pick the operation, bit 1 picks the direction.
  always_comb begin
    op        = OP_NONE;
    dst_is_rm = 1'b1;
    if (opcode[7:6] == 2'b00 && opcode[2] == 1'b0 && opcode[0] == 1'b1) begin
      dst_is_rm = ~opcode[1];
      unique case (opcode[5:3])
        3'd0:    op = OP_ADD;
        3'd1:    op = OP_OR;
        3'd4:    op = OP_AND;
        3'd5:    op = OP_SUB;
        3'd6:    op = OP_XOR;
        3'd7:    op = OP_CMP;
        default: op = OP_NONE;
      endcase
    end else if (opcode == OPC_UNARY && reg_fld == SUBOP_INV) begin
      op        = OP_NOT;
      dst_is_rm = 1'b1;
    end
  end

  assign wr_req  = (op != OP_NONE) && (op != OP_CMP);
  assign flg_upd = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e             op,
  input  logic                dst_is_rm,
  input  logic [DATA_W-1:0]   reg_opnd,
  input  logic [DATA_W-1:0]   rm_opnd,
  output logic [DATA_W-1:0]   alu_res,
  output alu_flags_t          alu_flags
);
  localparam int XW = DATA_W + 1;

  logic [DATA_W-1:0] dst_v, src_v;
  logic [XW-1:0]     a_x, b_x, sum_x;
  logic              is_sub;

  always_comb begin
    dst_v  = dst_is_rm ? rm_opnd  : reg_opnd;
    src_v  = dst_is_rm ? reg_opnd : rm_opnd;
    is_sub = (op == OP_SUB) || (op == OP_CMP);
    // One guard bit of sign extension makes the sum exact for signed inputs
    a_x    = {dst_v[DATA_W-1], dst_v};
    b_x    = {src_v[DATA_W-1], src_v};
    if (is_sub) b_x = ~b_x;
    sum_x  = a_x + b_x + {{(XW-1){1'b0}}, is_sub};
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: alu_res = sum_x[DATA_W-1:0];
      OP_AND:                 alu_res = dst_v & src_v;
      OP_OR:                  alu_res = dst_v | src_v;
      OP_XOR:                 alu_res = dst_v ^ src_v;
      OP_NOT:                 alu_res = ~dst_v;
      default:                alu_res = '0;
    endcase
  end

  always_comb begin
    alu_flags.sf = sum_x[DATA_W-1];
    alu_flags.zf = ~|sum_x[DATA_W-1:0];
    alu_flags.of = sum_x[XW-1] ^ sum_x[DATA_W-1];
  end
endmodule

// File: rtl/regmem_alu.sv
module regmem_alu
  import alu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        opcode,
  input  logic [2:0]        reg_fld,
  input  logic [DATA_W-1:0] reg_opnd,
  input  logic [DATA_W-1:0] rm_opnd,
  output logic [DATA_W-1:0] result,
  output logic              dest_is_rm,
  output logic              wr_en,
  output logic              sf,
  output logic              zf,
  output logic              of
);
  logic              rst_sync_n;
  alu_op_e           dec_op;
  logic              dec_dst_rm, dec_wr, dec_flg;
  logic [DATA_W-1:0] alu_res;
  alu_flags_t        alu_flags;

  logic [DATA_W-1:0] res_d, res_q;
  logic              dst_d, dst_q;
  logic              we_d, we_q;
  alu_flags_t        flg_d, flg_q;

  alu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  alu_decode u_dec (
    .opcode    (opcode),
    .reg_fld   (reg_fld),
    .op        (dec_op),
    .dst_is_rm (dec_dst_rm),
    .wr_req    (dec_wr),
    .flg_upd   (dec_flg)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op        (dec_op),
    .dst_is_rm (dec_dst_rm),
    .reg_opnd  (reg_opnd),
    .rm_opnd   (rm_opnd),
    .alu_res   (alu_res),
    .alu_flags (alu_flags)
  );

  // Next state: result and destination load on a write, flags on an
  // arithmetic or compare operation; otherwise both hold.
  always_comb begin
    res_d = res_q;
    dst_d = dst_q;
    flg_d = flg_q;
    we_d  = dec_wr;
    if (dec_wr) begin
      res_d = alu_res;
      dst_d = dec_dst_rm;
    end
    if (dec_flg) flg_d = alu_flags;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      dst_q <= 1'b0;
      we_q  <= 1'b0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      dst_q <= dst_d;
      we_q  <= we_d;
      flg_q <= flg_d;
    end
  end

  assign result     = res_q;
  assign dest_is_rm = dst_q;
  assign wr_en      = we_q;
  assign sf         = flg_q.sf;
  assign zf         = flg_q.zf;
  assign of         = flg_q.of;
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        opcode,
  input logic [2:0]        reg_fld,
  input logic [DATA_W-1:0] rm_opnd,
  input logic [DATA_W-1:0] result,
  input logic              dest_is_rm,
  input logic              wr_en,
  input logic              sf,
  input logic              zf,
  input logic              of
);
  logic is_logic, is_arith, is_cmp, is_inv, known, to_rm, to_reg;

  always_comb begin
    is_logic = opcode inside {8'h21, 8'h23, 8'h09, 8'h0B, 8'h31, 8'h33};
    is_arith = opcode inside {8'h01, 8'h03, 8'h29, 8'h2B};
    is_cmp   = opcode inside {8'h39, 8'h3B};
    is_inv   = (opcode == 8'hF7) && (reg_fld == 3'b010);
    known    = is_logic || is_arith || is_cmp || is_inv;
    to_rm    = opcode inside {8'h01, 8'h29, 8'h21, 8'h09, 8'h31};
    to_reg   = opcode inside {8'h03, 8'h2B, 8'h23, 8'h0B, 8'h33};
  end

  a_r2_to_rm: assert property (@(posedge clk) disable iff (!rst_n)
    to_rm |=> (wr_en && dest_is_rm));
  a_r2_to_reg: assert property (@(posedge clk) disable iff (!rst_n)
    to_reg |=> (wr_en && !dest_is_rm));
  a_r5_logic_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |=> (wr_en && $stable({sf, zf, of})));
  a_r6_invert: assert property (@(posedge clk) disable iff (!rst_n)
    is_inv |=> (wr_en && dest_is_rm && result == ~$past(rm_opnd) && $stable({sf, zf, of})));
  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> !wr_en);
  a_r8_sign_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_arith |=> (zf == (result == '0) && sf == result[DATA_W-1]));
  a_r10_unknown_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !known |=> (!wr_en && $stable({sf, zf, of})));
endmodule

bind regmem_alu alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .opcode     (opcode),
  .reg_fld    (reg_fld),
  .rm_opnd    (rm_opnd),
  .result     (result),
  .dest_is_rm (dest_is_rm),
  .wr_en      (wr_en),
  .sf         (sf),
  .zf         (zf),
  .of         (of)
);

// File: tb/sim_regmem_alu.sv
module sim_regmem_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  rf;
    logic [31:0] rv;
    logic [31:0] mv;
    logic [31:0] res;
    logic        we;
    logic        rm;
    logic [2:0]  flg;   // {sf, zf, of}
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'h01, 3'd0, 32'h10,       32'h1,        32'h11,       1'b1, 1'b1, 3'b000, 4'd3},  // R3 R2
    '{8'h03, 3'd0, 32'h10,       32'h1,        32'h11,       1'b1, 1'b0, 3'b000, 4'd2},  // R2 R3
    '{8'h29, 3'd0, 32'h1,        32'hA,        32'h9,        1'b1, 1'b1, 3'b000, 4'd4},  // R4 rm-reg
    '{8'h2B, 3'd0, 32'hA,        32'h1,        32'h9,        1'b1, 1'b0, 3'b000, 4'd4},  // R4 reg-rm
    '{8'h39, 3'd0, 32'h0A0B0C0D, 32'h0A0B0C07, 32'h0,        1'b0, 1'b0, 3'b100, 4'd7},  // R7 R8 negative
    '{8'h23, 3'd0, 32'h0A0B0C0D, 32'hFF,       32'h0D,       1'b1, 1'b0, 3'b100, 4'd5},  // R5 AND
    '{8'h09, 3'd0, 32'hA0B0C0D0, 32'h0A0B0C0D, 32'hAABBCCDD, 1'b1, 1'b1, 3'b100, 4'd5},  // R5 OR
    '{8'h31, 3'd0, 32'hA0B0C0D0, 32'hAABB0C0D, 32'h0A0BCCDD, 1'b1, 1'b1, 3'b100, 4'd5},  // R5 XOR
    '{8'h33, 3'd0, 32'hA0B0C0D0, 32'h0A0B0C0D, 32'hAABBCCDD, 1'b1, 1'b0, 3'b100, 4'd5},  // R5 XOR
    '{8'h21, 3'd0, 32'hFF,       32'h0A0B0C0D, 32'h0D,       1'b1, 1'b1, 3'b100, 4'd5},  // R5 AND
    '{8'hF7, 3'd2, 32'h12345678, 32'h0F0F00FF, 32'hF0F0FF00, 1'b1, 1'b1, 3'b100, 4'd6},  // R6
    '{8'h3B, 3'd0, 32'h0A0B0C0D, 32'h0A0B0C0D, 32'h0,        1'b0, 1'b0, 3'b010, 4'd7},  // R7 equal
    '{8'h0B, 3'd0, 32'h0,        32'h0,        32'h0,        1'b1, 1'b0, 3'b010, 4'd5},  // R5 zero OR
    '{8'h3B, 3'd0, 32'h0A0B0C0D, 32'h0A0B0C07, 32'h0,        1'b0, 1'b0, 3'b000, 4'd7},  // R7 positive
    '{8'h3B, 3'd0, 32'h80000000, 32'h1,        32'h0,        1'b0, 1'b0, 3'b001, 4'd9},  // R9 cmp ovf
    '{8'h90, 3'd0, 32'h5,        32'h5,        32'h0,        1'b0, 1'b0, 3'b001, 4'd10}, // R10
    '{8'hF7, 3'd3, 32'h5,        32'h5,        32'h0,        1'b0, 1'b0, 3'b001, 4'd6},  // R6 other subop
    '{8'h11, 3'd0, 32'h5,        32'h5,        32'h0,        1'b0, 1'b0, 3'b001, 4'd10}, // R10
    '{8'h01, 3'd0, 32'h7FFFFFFF, 32'h1,        32'h80000000, 1'b1, 1'b1, 3'b101, 4'd9},  // R9 add ovf
    '{8'h03, 3'd0, 32'hFFFFFFFF, 32'h1,        32'h0,        1'b1, 1'b0, 3'b010, 4'd8},  // R8 zero
    '{8'h29, 3'd0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 1'b1, 1'b1, 3'b101, 4'd9},  // R9 sub ovf
    '{8'h2B, 3'd0, 32'h5,        32'h7,        32'hFFFFFFFE, 1'b1, 1'b0, 3'b100, 4'd8},  // R8 negative
    '{8'h39, 3'd0, 32'h1,        32'h80000000, 32'h0,        1'b0, 1'b0, 3'b001, 4'd9},  // R9 cmp ovf
    '{8'h01, 3'd0, 32'h80000000, 32'h80000000, 32'h0,        1'b1, 1'b1, 3'b011, 4'd9},  // R9 R8
    '{8'hF7, 3'd2, 32'h0,        32'h0,        32'hFFFFFFFF, 1'b1, 1'b1, 3'b011, 4'd6},  // R6 hold
    '{8'h2B, 3'd0, 32'h3,        32'h3,        32'h0,        1'b1, 1'b0, 3'b010, 4'd8}   // R8 zero
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  opcode;
  logic [2:0]  reg_fld;
  logic [31:0] reg_opnd, rm_opnd, result;
  logic        dest_is_rm, wr_en, sf, zf, of;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regmem_alu u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .reg_fld(reg_fld),
    .reg_opnd(reg_opnd), .rm_opnd(rm_opnd), .result(result),
    .dest_is_rm(dest_is_rm), .wr_en(wr_en), .sf(sf), .zf(zf), .of(of)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] o, input logic [2:0] r,
                       input logic [31:0] a, input logic [31:0] b);
    opcode = o; reg_fld = r; reg_opnd = a; rm_opnd = b;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(8'h01, 3'd0, 32'h5, 32'h5);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset result", result, 32'h0);
    chk("R1 in reset wr_en/flags", {wr_en, dest_is_rm, sf, zf, of}, 32'h0);

    @(negedge clk);
    drive(8'h90, 3'd0, 32'h5, 32'h5);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 after release idle", {result[7:0], wr_en, dest_is_rm, sf, zf, of}, 32'h0);

    // R11: no change before the edge, new value just after it
    @(negedge clk);
    drive(8'h01, 3'd0, 32'h2, 32'h3);
    #1;
    chk("R11 before edge", {wr_en, result[7:0]}, 32'h0);
    @(posedge clk);
    #1;
    chk("R11 after edge", {wr_en, result[7:0]}, {23'd0, 1'b1, 8'h05});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].op, VECS[i].rf, VECS[i].rv, VECS[i].mv);
      @(posedge clk);
      #1;
      chk($sformatf("R%0d row %0d wr_en", VECS[i].req, i), {31'd0, wr_en}, {31'd0, VECS[i].we});
      if (VECS[i].we) begin
        chk($sformatf("R%0d row %0d result", VECS[i].req, i), result, VECS[i].res);
        chk($sformatf("R%0d row %0d dest_is_rm", VECS[i].req, i), {31'd0, dest_is_rm}, {31'd0, VECS[i].rm});
      end
      chk($sformatf("R%0d row %0d flags", VECS[i].req, i), {29'd0, sf, zf, of}, {29'd0, VECS[i].flg});
    end

    // R1: reset mid-run clears state without a clock edge
    @(negedge clk);
    drive(8'h90, 3'd0, 32'h0, 32'h0);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {result[7:0], wr_en, dest_is_rm, sf, zf, of}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 after second release", {wr_en, sf, zf, of}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule